// File: doc/BRIEF.md
# Frame-Timed Liveness Heartbeat

This block produces a slow square wave on an open-drain pin so that an outside controller can confirm the processing core is alive. The wave is not timed from the system clock. It is timed by counting frame strobes from the serial audio interface. Each strobe is a one-cycle pulse taken from the left/right clock, so one strobe arrives per audio frame. If audio traffic stops, the heartbeat freezes. A watcher that sees no edges, or edges at the wrong spacing, learns that the core or its audio path has failed.

Software sets the number of frames in one half-period. For a 100 ms half-period this is 4800 at 48 kHz or 4410 at 44.1 kHz. The value is captured only while the block is disabled. Once enabled, the block counts strobes. Each time the count completes, it flips the pin between released (pulled high outside the chip) and driven low. The single output is a drive-low request for the pad.

Top module: `frame_heartbeat`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pull_low` is 0 (pin released) and the frame count is zero. Asserting reset in the middle of a phase releases the pin, and a later enabled run needs the full count again before its first toggle.
- R2: While `enable` is 0, `pull_low` is 0 and frame strobes have no effect. Each such cycle captures `phase_len` as the active half-period length.
- R3: While `enable` is 1, every cycle with `frame_stb`=1 advances the count by one. On the strobe that completes the captured length L, the count returns to zero and `pull_low` inverts. The first inversion after enabling drives the pin low (`pull_low`=1).
- R4: Changes to `phase_len` while `enable` is 1 do not alter the active length.
- R5: While enabled and no strobe arrives, `pull_low` keeps its level for any number of cycles.
- R6: A captured `phase_len` of 0 acts as 1. Both 0 and 1 invert the output on every strobe.
- R7: `pull_low` is registered. It changes at the clock edge that samples the completing strobe and at no other edge while enabled.
- R8: When `enable` falls, the pin is released and the count is cleared at the next edge. The next enabled run starts its count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per audio frame |
| enable | input | 1 | 1 runs the heartbeat, 0 idles it and loads the length |
| phase_len | input | LEN_W | Frames per half-period, captured while disabled |
| pull_low | output | 1 | 1 drives the open-drain pin low, 0 releases it |

## Verification
A narrow length field is swept across every value, including 0 and 1. For each value, strobes arrive back to back or separated by idle gaps of varying size. This separates counting on strobes from counting on clock cycles. Further runs test how strobes behave while disabled, how the block behaves when disabled in mid-phase, how `phase_len` is handled when rewritten during a run, how level holds over a long idle stretch, and how reset behaves mid-phase. Expected levels come from counting strobes in the bench and dividing by the length.

// File: rtl/fhb_pkg.sv
package fhb_pkg;

    // Drive request for the open-drain pad.
    typedef enum logic {
        PIN_RELEASE = 1'b0,
        PIN_PULL    = 1'b1
    } pin_e;

    function automatic pin_e pin_flip(input pin_e cur);
        return (cur == PIN_PULL) ? PIN_RELEASE : PIN_PULL;
    endfunction

endpackage

// File: rtl/fhb_len_reg.sv
module fhb_len_reg #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    output logic [LEN_W-1:0] len_q
);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(1);

    typedef struct packed {
        logic [LEN_W-1:0] len;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            // zero is treated as the shortest legal phase
            st_d.len = (len_in == '0) ? MIN_LEN : len_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.len <= MIN_LEN;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_q = st_q.len;
endmodule

// File: rtl/fhb_frame_cnt.sv
module fhb_frame_cnt #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             stb,
    input  logic [LEN_W-1:0] limit,
    output logic             wrap,
    output logic [LEN_W-1:0] cnt_q
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [LEN_W-1:0] last_idx;
    logic             at_last;

    assign last_idx = limit - ONE;
    assign at_last  = (st_q.cnt == last_idx);

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (stb) begin
            if (at_last) begin
                st_d.cnt = '0;
                wrap     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
endmodule

// File: rtl/fhb_level.sv
module fhb_level
    import fhb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wrap,
    output logic pull_low
);
    typedef struct packed {
        pin_e pin;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.pin = PIN_RELEASE;
        end else if (wrap) begin
            st_d.pin = pin_flip(st_q.pin);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pin <= PIN_RELEASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_low = (st_q.pin == PIN_PULL);
endmodule

// File: rtl/frame_heartbeat.sv
module frame_heartbeat #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             enable,
    input  logic [LEN_W-1:0] phase_len,
    output logic             pull_low
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic             wrap;

    fhb_len_reg #(.LEN_W(LEN_W)) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (!enable),
        .len_in (phase_len),
        .len_q  (len_q)
    );

    fhb_frame_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .stb   (frame_stb),
        .limit (len_q),
        .wrap  (wrap),
        .cnt_q (cnt_q)
    );

    fhb_level u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .wrap     (wrap),
        .pull_low (pull_low)
    );
endmodule

// File: rtl/fhb_checker.sv
module fhb_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_stb,
    input logic             enable,
    input logic             pull_low,
    input logic [LEN_W-1:0] len_q,
    input logic [LEN_W-1:0] cnt_q
);
    a_r1_release_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pull_low && cnt_q == '0));

    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pull_low);

    a_r4_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(len_q));

    a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !frame_stb) |=> $stable(pull_low));

    a_r6_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        len_q != '0);

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len_q);

    a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> cnt_q == '0);
endmodule

bind frame_heartbeat fhb_checker #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .enable    (enable),
    .pull_low  (pull_low),
    .len_q     (len_q),
    .cnt_q     (cnt_q)
);

// File: tb/frame_heartbeat_tb.sv
module frame_heartbeat_tb;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_stb = 1'b0;
    logic          enable = 1'b0;
    logic [LW-1:0] phase_len = '0;
    logic          pull_low;

    int total = 0;
    int bad = 0;
    int m_cnt = 0;
    int m_len = 1;
    bit m_lvl = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frame_heartbeat #(.LEN_W(LW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .enable    (enable),
        .phase_len (phase_len),
        .pull_low  (pull_low)
    );

    task automatic check(input string req, input bit exp);
        total++;
        if (pull_low !== exp) begin
            bad++;
            $display("FAIL %s pull_low=%0b expected=%0b t=%0t", req, pull_low, exp, $time);
        end
    endtask

    // one clock; called and returns at a negedge
    task automatic tick(input bit stb);
        frame_stb = stb;
        @(posedge clk);
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic model_stb();
        if (enable) begin
            m_cnt++;
            if (m_cnt >= m_len) begin
                m_cnt = 0;
                m_lvl = ~m_lvl;
            end
        end
    endtask

    task automatic disable_load(input int len);
        enable = 1'b0;
        phase_len = LW'(len);
        tick(1'b0);
        m_len = (len == 0) ? 1 : len;
        m_cnt = 0;
        m_lvl = 1'b0;
        check("R2", 1'b0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog pull_low=%0b expected=finish", pull_low);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check("R1", 1'b0);
        tick(1'b1);
        check("R1", 1'b0);
        rst_n = 1'b1;
        tick(1'b0);
        check("R1", 1'b0);

        // R3 R6 R7: sweep every length with varied strobe gaps
        for (int len = 0; len < (1 << LW); len++) begin
            disable_load(len);
            enable = 1'b1;
            for (int s = 0; s < 2 * m_len + 1; s++) begin
                for (int g = 0; g < (s + len) % 3; g++) begin
                    tick(1'b0);
                    check("R5", m_lvl);
                end
                tick(1'b1);
                model_stb();
                check((len < 2) ? "R6" : "R3", m_lvl);
            end
        end

        // R2: strobes while disabled do nothing
        disable_load(3);
        for (int i = 0; i < 7; i++) begin
            tick(1'b1);
            check("R2", 1'b0);
        end

        // R8: drop enable in the low phase, then full count again
        enable = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(1'b1);
            model_stb();
        end
        check("R3", 1'b1);
        enable = 1'b0;
        tick(1'b0);
        check("R8", 1'b0);
        enable = 1'b1;
        m_cnt = 0;
        m_lvl = 1'b0;
        tick(1'b1);
        tick(1'b1);
        check("R8", 1'b0);
        tick(1'b1);
        check("R8", 1'b1);

        // R4: rewriting the length while running is ignored
        disable_load(5);
        enable = 1'b1;
        phase_len = LW'(2);
        for (int i = 1; i <= 5; i++) begin
            tick(1'b1);
            check("R4", i == 5);
        end

        // R5: long silence holds the low level
        for (int i = 0; i < 200; i++) begin
            tick(1'b0);
            if (i % 20 == 0) check("R5", 1'b1);
        end
        check("R5", 1'b1);

        // R1: reset in mid-phase releases and clears the count
        disable_load(4);
        enable = 1'b1;
        tick(1'b1);
        tick(1'b1);
        rst_n = 1'b0;
        tick(1'b0);
        check("R1", 1'b0);
        rst_n = 1'b1;
        enable = 1'b0;
        phase_len = LW'(3);
        tick(1'b0);
        enable = 1'b1;
        tick(1'b1);
        tick(1'b1);
        check("R1", 1'b0);
        tick(1'b1);
        check("R1", 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule